// File: doc/BRIEF.md
# I2C Bus Deadlock Recovery Sequencer

This block frees an I2C bus after a reset has left a slave partway through a transfer and holding the data line low. It owns the two bus lines through open-drain drive-low enables and watches their levels through a two-flop synchronizer. A start request makes it look at the data line first. If the data line is already high, it skips straight to a burst of START conditions. If the data line is low, it pulses the clock line, one low phase and one released phase per pulse, and after each pulse checks whether both lines now read high. It gives up after a bounded number of pulses.

When the lines come free, the sequencer sends a fixed number of back-to-back START conditions. These let the slave's bus logic settle into a known state. It then finishes with a one-cycle done pulse and an error flag that tells whether recovery worked. A line is only ever driven low. A high level always comes from releasing the line. The pulse phase uses a fixed abort delay given as a parameter in clock cycles. The START burst uses a half-period count given at an input port, so one instance can serve several bus speeds. For example, 100 kHz needs a 5 us half period, which is 500 cycles of a 100 MHz clock.

Top module: `i2cu_recover`

## Requirements
- R1: Out of reset, and whenever the block is idle, busy, done and error stay low (error keeps its last result once a run has ended) and both drive-low enables are deasserted.
- R2: A start accepted while the synchronized data line reads high skips the pulsing phase. The START burst begins in the cycle right after the accepting edge.
- R3: A start accepted while the synchronized data line reads low begins clock pulses. Each pulse drives the clock line low for ABORT_CYC cycles and then releases it for ABORT_CYC cycles. The data line is not driven during the pulses.
- R4: At the end of each released phase, both lines are sampled. If both read high, pulsing stops and the START burst begins in the next cycle.
- R5: At most MAX_PULSES pulses (16 by default) are issued. If the lines are still not both high after the last one, the run ends with error high and no START condition.
- R6: On success, NUM_STARTS (5 by default) START conditions follow back to back. Each has four steps, each lasting one half period, in this order: release data, release clock, drive data low, drive clock low.
- R7: The half period is half_i clock cycles, sampled live. A value of 0 behaves as 1.
- R8: Completion is marked by done high for exactly one cycle, with both enables deasserted in that cycle. Busy is low in the following cycle.
- R9: Error is cleared in the cycle after a start is accepted. It is valid from the done cycle until the next accepted start.
- R10: A start request that arrives while busy is high has no effect on the run in progress.
- R11: Line levels are used only after two synchronizer stages. A data line that rises at the same edge as the start is accepted is still treated as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a recovery run (taken only when idle) |
| scl_i | input | 1 | Clock line level from the pad (asynchronous) |
| sda_i | input | 1 | Data line level from the pad (asynchronous) |
| half_i | input | CW | START half period in clock cycles |
| scl_drive_low_o | output | 1 | Pull clock line low when high |
| sda_drive_low_o | output | 1 | Pull data line low when high |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| error_o | output | 1 | Last run failed to free the bus |

## Verification
The outputs decode directly from state. The first cycle after the edge that accepts a start therefore already shows either the first low phase of a pulse or the first START step. Each later step lands exactly ABORT_CYC or max(half_i,1) cycles after the one before it. The decision at the end of a pulse uses line levels from two edges earlier, so the bench's slave model releases the data line well inside the released phase. The bench builds the full expected waveform as a per-cycle queue at the accepting edge and compares every output at each falling clock edge, halfway between decisions. The done and error values are due in the cycle after the final step.

// File: rtl/i2cu_pkg.sv
package i2cu_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PULSE_LO,
      ST_PULSE_HI,
      ST_STEP_DAT_UP,
      ST_STEP_CLK_UP,
      ST_STEP_DAT_DN,
      ST_STEP_CLK_DN,
      ST_FINISH
   } rec_state_e;

endpackage

// File: rtl/i2cu_sync.sv
module i2cu_sync #(
   parameter int             W       = 2,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cu_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= {STAGES{RST_VAL[i]}};
         else        sh <= {sh[STAGES-2:0], d[i]};
      end
      assign q[i] = sh[STAGES-1];
   end

endmodule

// File: rtl/i2cu_step_timer.sv
module i2cu_step_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic [W-1:0] limit,
   output logic         expire
);

   logic [W-1:0] cnt;

   // expire on the last cycle of a step: count+1 reaches limit (limit 0 acts as 1)
   assign expire = ({1'b0, cnt} + {{W{1'b0}}, 1'b1}) >= {1'b0, limit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/i2cu_drive_map.sv
module i2cu_drive_map
   import i2cu_pkg::*;
(
   input  rec_state_e st,
   input  logic       later_rep,
   output logic       scl_dl,
   output logic       sda_dl
);

   always_comb begin
      scl_dl = 1'b0;
      sda_dl = 1'b0;
      case (st)
         ST_PULSE_LO:    scl_dl = 1'b1;
         ST_STEP_DAT_UP: scl_dl = later_rep;   // clock still low from previous START
         ST_STEP_DAT_DN: sda_dl = 1'b1;
         ST_STEP_CLK_DN: begin
            scl_dl = 1'b1;
            sda_dl = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/i2cu_recover.sv
module i2cu_recover
   import i2cu_pkg::*;
#(
   parameter int CW         = 16,
   parameter int ABORT_CYC  = 6200,
   parameter int MAX_PULSES = 16,
   parameter int NUM_STARTS = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          scl_i,
   input  logic          sda_i,
   input  logic [CW-1:0] half_i,
   output logic          scl_drive_low_o,
   output logic          sda_drive_low_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          error_o
);

   localparam int AW = $clog2(ABORT_CYC + 1);
   localparam int TW = (AW > CW) ? AW : CW;
   localparam int PW = $clog2(MAX_PULSES + 1);
   localparam int RW = $clog2(NUM_STARTS + 1);

   if (ABORT_CYC < 4) begin : g_bad_abort
      $error("i2cu_recover: ABORT_CYC must cover synchronizer latency (>= 4)");
   end
   if (MAX_PULSES < 1) begin : g_bad_pulses
      $error("i2cu_recover: MAX_PULSES must be at least 1");
   end
   if (NUM_STARTS < 1) begin : g_bad_starts
      $error("i2cu_recover: NUM_STARTS must be at least 1");
   end
   if (CW < 1) begin : g_bad_cw
      $error("i2cu_recover: CW must be at least 1");
   end

   rec_state_e    st, st_n;
   logic [PW-1:0] pulses, pulses_n;
   logic [RW-1:0] rep, rep_n;
   logic          err_q, err_n;
   logic          step_clr, expire;
   logic [TW-1:0] limit;
   logic [1:0]    line_s;
   logic          scl_s, sda_s;

   i2cu_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (line_s)
   );
   assign scl_s = line_s[1];
   assign sda_s = line_s[0];

   i2cu_step_timer #(.W(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (step_clr),
      .limit  (limit),
      .expire (expire)
   );

   always_comb begin
      st_n     = st;
      pulses_n = pulses;
      rep_n    = rep;
      err_n    = err_q;
      step_clr = 1'b0;
      limit    = TW'(ABORT_CYC);
      case (st)
         ST_IDLE: begin
            step_clr = 1'b1;
            if (start_i) begin
               err_n = 1'b0;
               if (sda_s) begin
                  st_n  = ST_STEP_DAT_UP;
                  rep_n = '0;
               end else begin
                  st_n     = ST_PULSE_LO;
                  pulses_n = '0;
               end
            end
         end
         ST_PULSE_LO: if (expire) begin
            step_clr = 1'b1;
            st_n     = ST_PULSE_HI;
         end
         ST_PULSE_HI: if (expire) begin
            step_clr = 1'b1;
            pulses_n = pulses + PW'(1);
            if (scl_s && sda_s) begin
               st_n  = ST_STEP_DAT_UP;
               rep_n = '0;
            end else if (pulses_n == PW'(MAX_PULSES)) begin
               st_n  = ST_FINISH;
               err_n = 1'b1;
            end else begin
               st_n = ST_PULSE_LO;
            end
         end
         ST_STEP_DAT_UP: begin
            limit = TW'(half_i);
            if (expire) begin
               step_clr = 1'b1;
               st_n     = ST_STEP_CLK_UP;
            end
         end
         ST_STEP_CLK_UP: begin
            limit = TW'(half_i);
            if (expire) begin
               step_clr = 1'b1;
               st_n     = ST_STEP_DAT_DN;
            end
         end
         ST_STEP_DAT_DN: begin
            limit = TW'(half_i);
            if (expire) begin
               step_clr = 1'b1;
               st_n     = ST_STEP_CLK_DN;
            end
         end
         ST_STEP_CLK_DN: begin
            limit = TW'(half_i);
            if (expire) begin
               step_clr = 1'b1;
               if (rep == RW'(NUM_STARTS - 1)) begin
                  st_n = ST_FINISH;
               end else begin
                  rep_n = rep + RW'(1);
                  st_n  = ST_STEP_DAT_UP;
               end
            end
         end
         ST_FINISH: begin
            step_clr = 1'b1;
            st_n     = ST_IDLE;
         end
         default: begin
            step_clr = 1'b1;
            st_n     = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         pulses <= '0;
         rep    <= '0;
         err_q  <= 1'b0;
      end else begin
         st     <= st_n;
         pulses <= pulses_n;
         rep    <= rep_n;
         err_q  <= err_n;
      end
   end

   i2cu_drive_map u_map (
      .st        (st),
      .later_rep (rep != '0),
      .scl_dl    (scl_drive_low_o),
      .sda_dl    (sda_drive_low_o)
   );

   assign busy_o  = (st != ST_IDLE);
   assign done_o  = (st == ST_FINISH);
   assign error_o = err_q;

   // R1: an idle block leaves both lines free
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!scl_drive_low_o && !sda_drive_low_o));

   // R5: the pulse count never passes its bound
   a_r5_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pulses <= PW'(MAX_PULSES));

   // R6: inside a run, the two enables never change in the same cycle
   a_r6_one_line_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && $past(busy_o)) |->
         !((scl_drive_low_o != $past(scl_drive_low_o)) &&
           (sda_drive_low_o != $past(sda_drive_low_o))));

   // R8: done is a single-cycle strobe that ends the run
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   // R9: an accepted start clears error and makes the block busy
   a_r9_error_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !error_o));

   // R9: with no start, an idle block keeps its error result
   a_r9_error_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(error_o));

   // R10: a start during a run does not end it
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o && !done_o) |=> busy_o);

endmodule

// File: tb/i2cu_recover_test.sv
module i2cu_recover_test;

   localparam int CW    = 8;
   localparam int ABORT = 6;
   localparam int MAXP  = 16;
   localparam int NST   = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n   = 1'b0;
   logic          start_i = 1'b0;
   logic [CW-1:0] half_i  = 8'd2;
   logic          scl_dl, sda_dl, busy, done, err;

   // slave model: open-drain bus
   logic scl_hold = 1'b0, sda_hold = 1'b0;
   logic cfg_load = 1'b0, cfg_hold = 1'b0;
   int   rel_target = 0, edges = 0;
   logic scl_prev = 1'b1;
   wire  scl_line = !(scl_dl | scl_hold);
   wire  sda_line = !(sda_dl | sda_hold);

   always @(posedge clk) begin
      scl_prev <= scl_line;
      if (cfg_load) begin
         sda_hold <= cfg_hold;
         edges    <= 0;
      end else if (sda_hold && scl_line && !scl_prev) begin
         edges <= edges + 1;
         if (edges + 1 >= rel_target) sda_hold <= 1'b0;
      end
   end

   i2cu_recover #(.CW(CW), .ABORT_CYC(ABORT), .MAX_PULSES(MAXP), .NUM_STARTS(NST)) uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_i         (start_i),
      .scl_i           (scl_line),
      .sda_i           (sda_line),
      .half_i          (half_i),
      .scl_drive_low_o (scl_dl),
      .sda_drive_low_o (sda_dl),
      .busy_o          (busy),
      .done_o          (done),
      .error_o         (err)
   );

   typedef struct packed {
      logic scl;
      logic sda;
      logic bsy;
      logic dn;
      logic er;
   } exp_t;

   exp_t  eq[$];
   string tq[$];
   int    checks = 0, failures = 0;
   logic  last_err = 1'b0;
   bit    chk_en = 1'b0;
   bit    finished = 1'b0;

   task automatic cmp(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic push(int n, exp_t e, string tag);
      for (int k = 0; k < n; k++) begin
         eq.push_back(e);
         tq.push_back(tag);
      end
   endtask

   // reference comparison, every falling edge
   always @(negedge clk) begin
      exp_t  e;
      string t;
      if (chk_en) begin
         if (eq.size() > 0) begin
            e = eq.pop_front();
            t = tq.pop_front();
            if (e.dn) last_err = e.er;
         end else begin
            e = {1'b0, 1'b0, 1'b0, 1'b0, last_err};
            t = "R1";
         end
         cmp(t, "scl_drive_low", scl_dl, e.scl);
         cmp(t, "sda_drive_low", sda_dl, e.sda);
         cmp(t, "busy", busy, e.bsy);
         cmp(t, "done", done, e.dn);
         cmp(t, "error", err, e.er);
      end
   end

   // one recovery run; expected waveform built at the accepting edge
   task automatic run_case(bit init_low, int rel_after, bit scl_stuck, int h,
                           bit late, bit stray);
      int  p;
      bit  fail;
      int  hh;
      string atag, stag;
      hh = (h == 0) ? 1 : h;
      fail = 1'b0;
      p = 0;
      if (init_low) begin
         if (scl_stuck)              begin p = MAXP; fail = 1'b1; end
         else if (late)              p = 1;
         else if (rel_after <= MAXP) p = rel_after;
         else                        begin p = MAXP; fail = 1'b1; end
      end
      @(posedge clk); #2;
      half_i     = CW'(h);
      scl_hold   = scl_stuck;
      rel_target = rel_after;
      cfg_hold   = init_low;
      cfg_load   = 1'b1;
      @(posedge clk); #2;
      cfg_load = 1'b0;
      repeat (6) @(posedge clk);
      #2;
      start_i = 1'b1;
      if (late) begin          // R11: data line rises at the accepting edge
         cfg_hold = 1'b0;
         cfg_load = 1'b1;
      end
      @(posedge clk); #2;      // accepting edge has passed
      start_i  = 1'b0;
      cfg_load = 1'b0;
      atag = late ? "R11" : "R3";
      stag = (h == 0) ? "R7" : "R6";
      for (int i = 1; i <= p; i++) begin
         push(ABORT, {1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, (i == 1) ? "R9" : atag);
         push(ABORT, {1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, (i == p && !fail) ? "R4" : atag);
      end
      if (!fail) begin
         for (int r = 0; r < NST; r++) begin
            push(hh, {(r > 0), 1'b0, 1'b1, 1'b0, 1'b0}, (r == 0 && !init_low) ? "R2" : stag);
            push(hh, {1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, stag);
            push(hh, {1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, stag);
            push(hh, {1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, stag);
         end
      end
      push(1, {1'b0, 1'b0, 1'b1, 1'b1, fail}, fail ? "R5" : "R8");
      if (stray) begin         // R10: extra start mid-run
         repeat (4) @(posedge clk);
         #2 start_i = 1'b1;
         @(posedge clk); #2 start_i = 1'b0;
      end
      while (eq.size() != 0) @(posedge clk);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      cmp("R1", "busy in reset", busy, 1'b0);
      cmp("R1", "done in reset", done, 1'b0);
      cmp("R1", "error in reset", err, 1'b0);
      cmp("R1", "scl enable in reset", scl_dl, 1'b0);
      cmp("R1", "sda enable in reset", sda_dl, 1'b0);
      @(posedge clk); #2 rst_n = 1'b1;
      chk_en = 1'b1;
      repeat (3) @(posedge clk);

      run_case(1'b0, 0, 1'b0, 2, 1'b0, 1'b0);      // R2, R6: free bus
      run_case(1'b1, 3, 1'b0, 1, 1'b0, 1'b0);      // R3, R4: frees after 3 pulses
      run_case(1'b1, 1000, 1'b0, 2, 1'b0, 1'b0);   // R5: data stuck, fails
      run_case(1'b0, 0, 1'b0, 3, 1'b0, 1'b0);      // R9: error cleared by next run
      run_case(1'b1, 2, 1'b1, 2, 1'b0, 1'b0);      // R5: clock held by slave
      run_case(1'b1, 16, 1'b0, 1, 1'b0, 1'b0);     // R4: frees on the last allowed pulse
      run_case(1'b1, 17, 1'b0, 1, 1'b0, 1'b0);     // R5: one pulse too many
      run_case(1'b0, 0, 1'b0, 0, 1'b0, 1'b0);      // R7: half period 0 acts as 1
      run_case(1'b1, 2, 1'b0, 2, 1'b0, 1'b1);      // R10: start while busy ignored
      run_case(1'b1, 1000, 1'b0, 1, 1'b1, 1'b0);   // R11: late data release still pulses once

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R1 watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule